// File: doc/BRIEF.md
# Serial LCD-Controller Slave Port

This block is the host-facing serial port of a character LCD controller. A host drives a serial clock, an active-low chip select and a data line into the block, and reads a data line back. Every transfer opens with a start byte: a run of ones marks the start, and two flag bits follow it. One flag picks the direction and the other picks the target register. Each 8-bit word then travels as two serial bytes. Each byte carries one nibble in its low half and zero padding in its high half.

For writes, the block rebuilds each word and hands it to the controller core with a one-cycle strobe. If the core is still busy when the word's last bit arrives, the word is dropped. For reads, it returns either the core's status byte or RAM data that it asks the core for. The RAM data comes back over a request/valid pair. Words of the same kind can follow one another without a new start byte. While a read is in progress, a fresh run of ones on the input begins a new start byte.

The serial inputs are sampled in the system clock domain, and the block acts on the edges of the serial clock. The serial clock idles high. The host changes the data input on falling edges and samples the data output on rising edges.

Top module: `lcd_serial_slave`

## Requirements
- R1: A start byte is five consecutive ones sampled on rising serial-clock edges, then a direction bit (1 = read, 0 = write), then a register-select bit, then one more bit whose value is ignored. Bits count only while `cs_n` is low.
- R2: In write mode each word is 16 serial bits. Bits 0-3 carry word bits 0-3, least significant first. Bits 8-11 carry word bits 4-7, least significant first. When bit 15 is sampled and `core_busy` is low, `wr_stb` pulses high for exactly one clock, with the word on `wr_data` and the register-select flag on `wr_rs`.
- R3: In write mode the padding positions (bits 4-7 and 12-15 of each word) are ignored: nonzero padding changes neither the delivered word nor the framing.
- R4: After one start byte, any number of words follow back to back, each delivered as in R2, with no new start byte.
- R5: If `core_busy` is high when bit 15 of a write word is sampled, no `wr_stb` is issued for that word, and the next word is still framed normally.
- R6: In read mode with register select 0, each word returns `status_in`, captured at the falling edge that starts the word. It is sent in the same 16-bit layout as R2 and is driven on `sdo` from each falling edge until the next. Padding positions are driven 0.
- R7: In read mode with register select 1, `rd_req` pulses for one clock when the start byte is accepted and again after the last bit of each word. The word is taken from the most recent `rd_data` presented with `rd_valid` after that request.
- R8: If no valid RAM word is present at the falling edge that starts a read word, the block sends 0x00 for that word and sets `rd_err`, which stays high until reset.
- R9: In read mode, five consecutive ones on `sdi` are taken as a new start byte, whose direction and register-select bits then take effect.
- R10: While `cs_n` is high the framer returns to hunting for a start byte and `sdo` is driven 0. Partial words are discarded.
- R11: After reset `sdo`, `wr_stb`, `rd_req` and `rd_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host, idles high |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| core_busy | input | 1 | Core is still executing the previous word |
| wr_stb | output | 1 | One-clock strobe for a received word |
| wr_data | output | 8 | Received word |
| wr_rs | output | 1 | Register-select flag of the received word |
| rd_req | output | 1 | Request for the next RAM read word |
| rd_valid | input | 1 | RAM read word present on rd_data |
| rd_data | input | 8 | RAM read word from the core |
| status_in | input | 8 | Status byte from the core |
| rd_err | output | 1 | Sticky flag: a RAM word was not ready in time |

## Verification
The assertions take for granted that `sclk`, `cs_n` and `sdi` are synchronous to `clk`. They also assume that each serial-clock phase lasts several system clocks, that `sdi` is steady around every rising edge, and that `cs_n` changes only while `sclk` is high. The RAM answer is assumed to arrive within half a serial period, except where a late answer is the point of the test. The bench holds every serial phase for eight clocks and changes inputs only on falling system-clock edges. Its core model answers in three clocks, and in one case deliberately waits forty so that the invalid-read path is exercised.

// File: rtl/lcd_ser_pkg.sv
package lcd_ser_pkg;

    localparam int NIB_W      = 4;
    localparam int WORD_W     = 2 * NIB_W;
    localparam int FRAME_BITS = 4 * NIB_W;
    localparam int BIDX_W     = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        FR_HUNT,
        FR_HDR,
        FR_WR,
        FR_RD
    } fr_state_e;

    // Bit of a word carried at serial position idx of its 16-bit frame;
    // the high half of each byte is padding and reads as zero.
    function automatic logic frame_bit(input logic [WORD_W-1:0] w,
                                       input logic [BIDX_W-1:0] idx);
        if (idx[2]) return 1'b0;
        return w[{idx[3], idx[1:0]}];
    endfunction

endpackage

// File: rtl/lcd_ser_edge.sv
module lcd_ser_edge #(
    parameter bit IDLE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= IDLE_HIGH;
        else     sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;

endmodule

// File: rtl/lcd_ser_framer.sv
module lcd_ser_framer
    import lcd_ser_pkg::*;
#(
    parameter int SYNC_LEN = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              cs_n,
    input  logic              sdi,
    input  logic              core_busy,
    output logic              wr_stb,
    output logic [WORD_W-1:0] wr_data,
    output logic              wr_rs,
    output logic              rd_req,
    output logic              in_rd,
    output logic              rs_flag,
    output logic [BIDX_W-1:0] bidx
);
    localparam int SYNC_W = $clog2(SYNC_LEN + 1);

    fr_state_e         st;
    logic [SYNC_W-1:0] ones;
    logic [1:0]        hcnt;
    logic              rw_q;
    logic              rs_q;
    logic [WORD_W-1:0] shreg;

    logic sync_hit;
    assign sync_hit = sdi && (ones == SYNC_W'(SYNC_LEN - 1));

    always_ff @(posedge clk) begin
        wr_stb <= 1'b0;
        rd_req <= 1'b0;
        if (rst) begin
            st      <= FR_HUNT;
            ones    <= '0;
            hcnt    <= '0;
            rw_q    <= 1'b0;
            rs_q    <= 1'b0;
            bidx    <= '0;
            shreg   <= '0;
            wr_data <= '0;
            wr_rs   <= 1'b0;
        end else if (cs_n) begin
            st   <= FR_HUNT;
            ones <= '0;
            hcnt <= '0;
            bidx <= '0;
        end else if (rise) begin
            unique case (st)
                FR_HUNT: begin
                    if (sync_hit) begin
                        st   <= FR_HDR;
                        hcnt <= '0;
                        ones <= '0;
                    end else if (sdi) begin
                        ones <= ones + SYNC_W'(1);
                    end else begin
                        ones <= '0;
                    end
                end
                FR_HDR: begin
                    hcnt <= hcnt + 2'd1;
                    if (hcnt == 2'd0) begin
                        rw_q <= sdi;
                    end else if (hcnt == 2'd1) begin
                        rs_q <= sdi;
                    end else begin
                        st   <= rw_q ? FR_RD : FR_WR;
                        bidx <= '0;
                        ones <= '0;
                        if (rw_q && rs_q) rd_req <= 1'b1;
                    end
                end
                FR_WR: begin
                    if (!bidx[2]) shreg[{bidx[3], bidx[1:0]}] <= sdi;
                    if (bidx == BIDX_W'(FRAME_BITS - 1) && !core_busy) begin
                        wr_stb  <= 1'b1;
                        wr_data <= shreg;
                        wr_rs   <= rs_q;
                    end
                    bidx <= bidx + BIDX_W'(1);
                end
                FR_RD: begin
                    if (sync_hit) begin
                        st   <= FR_HDR;
                        hcnt <= '0;
                        ones <= '0;
                    end else begin
                        ones <= sdi ? ones + SYNC_W'(1) : '0;
                        bidx <= bidx + BIDX_W'(1);
                        if (bidx == BIDX_W'(FRAME_BITS - 1) && rs_q) rd_req <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign in_rd   = (st == FR_RD);
    assign rs_flag = rs_q;

    // R5
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && !cs_n && st == FR_WR && bidx == BIDX_W'(FRAME_BITS - 1) && core_busy)
        |=> !wr_stb);

    // R2
    stb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R10
    cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (st == FR_HUNT && !wr_stb && !rd_req));

    // R7
    rdreq_src_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (st == FR_RD && rs_q));

endmodule

// File: rtl/lcd_ser_tx.sv
module lcd_ser_tx
    import lcd_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fall,
    input  logic              cs_n,
    input  logic              in_rd,
    input  logic              rs_flag,
    input  logic [BIDX_W-1:0] bidx,
    input  logic              rd_req,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    input  logic [WORD_W-1:0] status_in,
    output logic              sdo,
    output logic              rd_err
);
    logic [WORD_W-1:0] hold_q;
    logic              hold_v;
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            hold_v <= 1'b0;
            word_q <= '0;
            sdo    <= 1'b0;
            rd_err <= 1'b0;
        end else begin
            if (cs_n) begin
                sdo <= 1'b0;
            end else if (fall) begin
                if (!in_rd) begin
                    sdo <= 1'b0;
                end else if (bidx == '0) begin
                    if (!rs_flag) begin
                        word_q <= status_in;
                        sdo    <= frame_bit(status_in, '0);
                    end else if (hold_v) begin
                        word_q <= hold_q;
                        sdo    <= frame_bit(hold_q, '0);
                        hold_v <= 1'b0;
                    end else begin
                        word_q <= '0;
                        sdo    <= 1'b0;
                        rd_err <= 1'b1;
                    end
                end else begin
                    sdo <= frame_bit(word_q, bidx);
                end
            end
            if (rd_req) hold_v <= 1'b0;
            if (rd_valid) begin
                hold_q <= rd_data;
                hold_v <= 1'b1;
            end
        end
    end

    // R6
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (fall && !cs_n && in_rd && bidx[2]) |=> !sdo);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        rd_err |=> rd_err);

    // R8
    late_word_chk: assert property (@(posedge clk) disable iff (rst)
        (fall && !cs_n && in_rd && bidx == '0 && rs_flag && !hold_v && !rd_valid)
        |=> (rd_err && !sdo));

endmodule

// File: rtl/lcd_serial_slave.sv
module lcd_serial_slave
    import lcd_ser_pkg::*;
#(
    parameter int SYNC_LEN = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    output logic              sdo,
    input  logic              core_busy,
    output logic              wr_stb,
    output logic [WORD_W-1:0] wr_data,
    output logic              wr_rs,
    output logic              rd_req,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    input  logic [WORD_W-1:0] status_in,
    output logic              rd_err
);
    logic              rise;
    logic              fall;
    logic              in_rd;
    logic              rs_flag;
    logic [BIDX_W-1:0] bidx;

    lcd_ser_edge #(.IDLE_HIGH(1'b1)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .rise (rise),
        .fall (fall)
    );

    lcd_ser_framer #(.SYNC_LEN(SYNC_LEN)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .rise      (rise),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .core_busy (core_busy),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .wr_rs     (wr_rs),
        .rd_req    (rd_req),
        .in_rd     (in_rd),
        .rs_flag   (rs_flag),
        .bidx      (bidx)
    );

    lcd_ser_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .fall      (fall),
        .cs_n      (cs_n),
        .in_rd     (in_rd),
        .rs_flag   (rs_flag),
        .bidx      (bidx),
        .rd_req    (rd_req),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .status_in (status_in),
        .sdo       (sdo),
        .rd_err    (rd_err)
    );

endmodule

// File: tb/sim_lcd_serial_slave.sv
module sim_lcd_serial_slave;

    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b1;
    logic       cs_n = 1'b1;
    logic       sdi = 1'b0;
    logic       sdo;
    logic       core_busy = 1'b0;
    logic       wr_stb;
    logic [7:0] wr_data;
    logic       wr_rs;
    logic       rd_req;
    logic       rd_valid = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic [7:0] status_in = 8'h00;
    logic       rd_err;

    int checks = 0;
    int errors = 0;
    int rdreq_n = 0;
    int pend = 0;
    int core_dly = 3;
    logic [8:0] exp_q[$];
    logic [7:0] ram_q[$];

    always #4 clk = ~clk;

    lcd_serial_slave u0 (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
        .core_busy(core_busy), .wr_stb(wr_stb), .wr_data(wr_data), .wr_rs(wr_rs),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
        .status_in(status_in), .rd_err(rd_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference for delivered words: every strobe must match the queue head.
    always @(negedge clk) begin
        if (!rst && wr_stb) begin
            if (exp_q.size() == 0) chk("R5 unexpected wr_stb", {23'd0, wr_rs, wr_data}, 32'h1ff);
            else chk("R2 delivered word", {23'd0, wr_rs, wr_data}, {23'd0, exp_q.pop_front()});
        end
    end

    // Core model: answers each RAM request after core_dly clocks.
    always @(negedge clk) begin
        rd_valid = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                rd_valid = 1'b1;
                rd_data = (ram_q.size() > 0) ? ram_q.pop_front() : 8'h00;
            end
        end
        if (!rst && rd_req) begin
            rdreq_n++;
            pend = core_dly;
        end
    end

    task automatic sbit(input logic b, output logic so);
        @(negedge clk);
        sclk = 1'b0;
        sdi = b;
        repeat (H) @(negedge clk);
        so = sdo;
        sclk = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic cs_on();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_off();
        @(negedge clk);
        sdi = 1'b0;
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic start(input logic rw, input logic rs);
        logic so;
        for (int i = 0; i < 5; i++) sbit(1'b1, so);
        sbit(rw, so);
        sbit(rs, so);
        sbit(1'b0, so);
    endtask

    task automatic write_word(input logic [7:0] d, input logic [3:0] pad);
        logic so;
        for (int i = 0; i < 4; i++) sbit(d[i], so);
        for (int i = 0; i < 4; i++) sbit(pad[i], so);
        for (int i = 4; i < 8; i++) sbit(d[i], so);
        for (int i = 0; i < 4; i++) sbit(pad[i], so);
    endtask

    task automatic read_word(output logic [7:0] w, output logic padbad);
        logic [15:0] b;
        for (int i = 0; i < 16; i++) sbit(1'b0, b[i]);
        w = {b[11:8], b[3:0]};
        padbad = |{b[15:12], b[7:4]};
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] w;
        logic pb;
        logic so;
        int base;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 sdo", sdo, 0);
        chk("R11 wr_stb", wr_stb, 0);
        chk("R11 rd_req", rd_req, 0);
        chk("R11 rd_err", rd_err, 0);

        // R1 R2: single write, register select 0
        cs_on();
        exp_q.push_back({1'b0, 8'h3C});
        start(1'b0, 1'b0);
        write_word(8'h3C, 4'h0);
        cs_off();
        chk("R1 word count after single write", exp_q.size(), 0);

        // R4: continuous writes, register select 1
        cs_on();
        start(1'b0, 1'b1);
        exp_q.push_back({1'b1, 8'h5A}); write_word(8'h5A, 4'h0);
        exp_q.push_back({1'b1, 8'hF0}); write_word(8'hF0, 4'h0);
        exp_q.push_back({1'b1, 8'h81}); write_word(8'h81, 4'h0);
        // R3: nonzero padding ignored, framing kept for the following word
        exp_q.push_back({1'b1, 8'h7E}); write_word(8'h7E, 4'hA);
        exp_q.push_back({1'b1, 8'h0F}); write_word(8'h0F, 4'hF);
        exp_q.push_back({1'b1, 8'hC3}); write_word(8'hC3, 4'h0);
        // R5: busy drops the word, next word still framed
        core_busy = 1'b1;
        write_word(8'h11, 4'h0);
        core_busy = 1'b0;
        exp_q.push_back({1'b1, 8'h22}); write_word(8'h22, 4'h0);
        cs_off();
        chk("R4 pending words after continuous writes", exp_q.size(), 0);

        // R6: status reads with zero padding
        cs_on();
        status_in = 8'hA5;
        start(1'b1, 1'b0);
        read_word(w, pb);
        chk("R6 status word 1", w, 8'hA5);
        chk("R6 padding word 1", pb, 0);
        status_in = 8'h3C;
        read_word(w, pb);
        chk("R6 status word 2", w, 8'h3C);
        chk("R6 padding word 2", pb, 0);
        cs_off();

        // R7: RAM reads via request/valid
        base = rdreq_n;
        ram_q.push_back(8'h12);
        ram_q.push_back(8'hEF);
        cs_on();
        start(1'b1, 1'b1);
        read_word(w, pb);
        chk("R7 ram word 1", w, 8'h12);
        read_word(w, pb);
        chk("R7 ram word 2", w, 8'hEF);
        chk("R7 ram padding", pb, 0);
        cs_off();
        chk("R7 request count", rdreq_n - base, 3);
        chk("R8 rd_err still clear", rd_err, 0);
        repeat (10) @(negedge clk);

        // R8: late RAM word gives zeros and a sticky error
        ram_q.delete();
        ram_q.push_back(8'h77);
        core_dly = 40;
        cs_on();
        start(1'b1, 1'b1);
        read_word(w, pb);
        cs_off();
        chk("R8 late word value", w, 8'h00);
        chk("R8 rd_err set", rd_err, 1);
        repeat (60) @(negedge clk);
        core_dly = 3;
        ram_q.delete();
        chk("R8 rd_err sticky", rd_err, 1);

        // R9: restart from inside a read into write mode
        cs_on();
        status_in = 8'h5C;
        start(1'b1, 1'b0);
        read_word(w, pb);
        chk("R9 read before restart", w, 8'h5C);
        start(1'b0, 1'b1);
        exp_q.push_back({1'b1, 8'h4D});
        write_word(8'h4D, 4'h0);
        cs_off();
        chk("R9 word after restart", exp_q.size(), 0);

        // R10: chip select aborts partial frames
        cs_on();
        start(1'b0, 1'b0);
        sbit(1'b1, so); sbit(1'b0, so); sbit(1'b1, so);
        sbit(1'b1, so); sbit(1'b0, so); sbit(1'b1, so);
        cs_off();
        cs_on();
        start(1'b0, 1'b0);
        exp_q.push_back({1'b0, 8'h6B});
        write_word(8'h6B, 4'h0);
        cs_off();
        chk("R10 only the clean word delivered", exp_q.size(), 0);

        cs_on();
        status_in = 8'hFF;
        start(1'b1, 1'b0);
        sbit(1'b0, so); sbit(1'b0, so); sbit(1'b0, so);
        chk("R6 sdo high on data bit", sdo, 1);
        @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 sdo low after deselect", sdo, 0);
        repeat (4) @(negedge clk);

        repeat (50) @(negedge clk);
        chk("R5 no stray words", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule